// File: doc/BRIEF.md
# Card interface power state sequencer

This block decides how the card-facing signal lines of a memory-card host are driven while the card supply is switched. It keeps the card from being fed through its own data, command and clock pins. After reset it drives every card line low: this is the power-cycle state. From there software asks for an idle-high state or for full power. A request for full power always passes through the idle-high state and stays there for a timed settling window before it releases the lines to the functional host logic.

The settling window is counted in ticks of an external timebase. With a 1 µs tick and the default length, the window is one millisecond. Once power-on is reached, the block holds it and ignores further requests. Only its reset brings the lines back to the power-cycle state. On the cycle in which power-on is entered, the block raises a single-cycle strobe so the host can reload its interrupt mask, which the reset cleared.

Top module: `psq_power_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status is power-cycle (00) and every card line is enabled and driven low.
- R2: In power-cycle (status 00) all data lines, the command line and the clock line have their enables at 1 and their levels at 0.
- R3: In power-off (status 01) and in the settling window (status 11) all of those lines have their enables at 1 and their levels at 1.
- R4: In power-on (status 10) every enable is 0 and every level is 0, so the lines belong to the functional host path.
- R5: A power-on request (mode 10) seen in power-cycle or power-off moves the status to 11 on the next clock. Power-on is entered on the clock edge at which the DWELL_TICKS-th tick is seen in the settling window. A tick on the edge that enters the window does not count.
- R6: The mode encoding is 00 power-cycle, 01 power-off, 10 power-on and 11 hold. In power-cycle, mode 01 moves to power-off on the next clock. In power-off, mode 00 moves to power-cycle on the next clock. Mode 11 leaves the state unchanged.
- R7: In the settling window, mode 10 or 11 keeps the count running. Mode 00 or 01 leaves at once for the requested state and discards the count, so a later window starts again from zero.
- R8: In power-on, every mode value is ignored. Only reset leaves power-on.
- R9: The acknowledge is 1 exactly while the status is power-on. The mask-reload strobe is 1 only in the first cycle of power-on.
- R10: The status port reports the current state with the encoding 00 power-cycle, 01 power-off, 10 power-on, 11 settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| mode_req_i | input | 2 | Requested mode: 00 cycle, 01 off, 10 on, 11 hold |
| dat_o | output | DW | Data line levels |
| dat_oe_o | output | DW | Data line enables |
| cmd_o | output | 1 | Command line level |
| cmd_oe_o | output | 1 | Command line enable |
| card_clk_o | output | 1 | Card clock line level |
| card_clk_oe_o | output | 1 | Card clock line enable |
| pwr_state_o | output | 2 | Current state (R10 encoding) |
| on_ack_o | output | 1 | Power-on reached |
| mask_reload_o | output | 1 | One-cycle strobe on entry to power-on |

## Verification
The bench checks the exact edge at which power-on is entered. A design with an off-by-one count would release the lines one tick early or late, and one that counted the entry tick would release them a tick early. It abandons a settling window partway and starts a new one, which catches a counter that is not cleared and so reaches power-on too soon. It sends power-cycle and power-off requests while powered on: a design that obeys them would drive the lines again behind the host's back. It also compares the strobe and the acknowledge on every cycle. A strobe that stays high, or an acknowledge raised during settling, shows up as a mismatch.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        PS_CYCLE = 2'b00,
        PS_OFF   = 2'b01,
        PS_ON    = 2'b10,
        PS_DWELL = 2'b11
    } pstate_e;

    typedef enum logic [1:0] {
        RQ_CYCLE = 2'b00,
        RQ_OFF   = 2'b01,
        RQ_ON    = 2'b10,
        RQ_HOLD  = 2'b11
    } preq_e;

    typedef struct packed {
        pstate_e state;
        logic    reload;
    } fsm_regs_t;

endpackage

// File: rtl/psq_dwell_timer.sv
module psq_dwell_timer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = 1'b0;
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                done_o = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: count never passes the last tick index
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: leaving the window discards the count
    a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/psq_line_drive.sv
module psq_line_drive #(
    parameter int DW = 8
) (
    input  psq_pkg::pstate_e state_i,
    output logic [DW-1:0]    dat_o,
    output logic [DW-1:0]    dat_oe_o,
    output logic             cmd_o,
    output logic             cmd_oe_o,
    output logic             ck_o,
    output logic             ck_oe_o
);
    import psq_pkg::*;

    logic own, high;

    always_comb begin
        own  = (state_i != PS_ON);
        high = (state_i == PS_OFF) || (state_i == PS_DWELL);
    end

    for (genvar i = 0; i < DW; i++) begin : g_dat
        assign dat_oe_o[i] = own;
        assign dat_o[i]    = own & high;
    end

    assign cmd_oe_o = own;
    assign cmd_o    = own & high;
    assign ck_oe_o  = own;
    assign ck_o     = own & high;

endmodule

// File: rtl/psq_fsm.sv
module psq_fsm (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_i,
    input  logic             dwell_done_i,
    output psq_pkg::pstate_e state_o,
    output logic             dwell_run_o,
    output logic             reload_o
);
    import psq_pkg::*;

    fsm_regs_t r_d, r_q;
    preq_e     req;

    always_comb begin
        req       = preq_e'(req_i);
        r_d       = r_q;
        r_d.reload = 1'b0;
        unique case (r_q.state)
            PS_CYCLE: begin
                if (req == RQ_OFF)     r_d.state = PS_OFF;
                else if (req == RQ_ON) r_d.state = PS_DWELL;
            end
            PS_OFF: begin
                if (req == RQ_CYCLE)   r_d.state = PS_CYCLE;
                else if (req == RQ_ON) r_d.state = PS_DWELL;
            end
            PS_DWELL: begin
                if (req == RQ_CYCLE)     r_d.state = PS_CYCLE;
                else if (req == RQ_OFF)  r_d.state = PS_OFF;
                else if (dwell_done_i) begin
                    r_d.state  = PS_ON;
                    r_d.reload = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PS_CYCLE, reload: 1'b0};
        else        r_q <= r_d;
    end

    assign state_o     = r_q.state;
    assign dwell_run_o = (r_q.state == PS_DWELL);
    assign reload_o    = r_q.reload;

    // R8: power-on is held until reset
    a_r8_on_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == PS_ON |=> r_q.state == PS_ON);

    // R5: power-on is entered only from a completed window
    a_r5_on_via_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_ON && $past(r_q.state) != PS_ON)
        |-> ($past(r_q.state) == PS_DWELL && $past(dwell_done_i)));

    // R9: reload strobe only on the first power-on cycle
    a_r9_reload_entry: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |-> (r_q.state == PS_ON && $past(r_q.state) == PS_DWELL));

endmodule

// File: rtl/psq_power_seq.sv
module psq_power_seq #(
    parameter int DW          = 8,
    parameter int DWELL_TICKS = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [1:0]    mode_req_i,
    output logic [DW-1:0] dat_o,
    output logic [DW-1:0] dat_oe_o,
    output logic          cmd_o,
    output logic          cmd_oe_o,
    output logic          card_clk_o,
    output logic          card_clk_oe_o,
    output logic [1:0]    pwr_state_o,
    output logic          on_ack_o,
    output logic          mask_reload_o
);
    import psq_pkg::*;

    pstate_e state;
    logic    run, done;

    psq_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (mode_req_i),
        .dwell_done_i (done),
        .state_o      (state),
        .dwell_run_o  (run),
        .reload_o     (mask_reload_o)
    );

    psq_dwell_timer #(.TICKS(DWELL_TICKS)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick_i),
        .done_o (done)
    );

    psq_line_drive #(.DW(DW)) i_lines (
        .state_i  (state),
        .dat_o    (dat_o),
        .dat_oe_o (dat_oe_o),
        .cmd_o    (cmd_o),
        .cmd_oe_o (cmd_oe_o),
        .ck_o     (card_clk_o),
        .ck_oe_o  (card_clk_oe_o)
    );

    assign pwr_state_o = state;
    assign on_ack_o    = (state == PS_ON);

    // R2: power-cycle drives everything low
    a_r2_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o == 2'b00 |-> (&dat_oe_o && dat_o == '0 && cmd_oe_o && !cmd_o
                                  && card_clk_oe_o && !card_clk_o));

    // R3: power-off and settling drive everything high
    a_r3_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o[0] |-> (&dat_oe_o && &dat_o && cmd_oe_o && cmd_o
                            && card_clk_oe_o && card_clk_o));

    // R4: power-on releases every line
    a_r4_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o == 2'b10 |-> (dat_oe_o == '0 && !cmd_oe_o && !card_clk_oe_o));

endmodule

// File: tb/test_psq_power_seq.sv
module test_psq_power_seq;

    localparam int DW = 8;
    localparam int NT = 1000;
    localparam int TDIV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [1:0]    req = 2'b11;
    logic [DW-1:0] dat, dat_oe;
    logic          cmd, cmd_oe, cck, cck_oe, ack, reload;
    logic [1:0]    st;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    psq_power_seq #(.DW(DW), .DWELL_TICKS(NT)) i_psq_power_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_req_i(req),
        .dat_o(dat), .dat_oe_o(dat_oe), .cmd_o(cmd), .cmd_oe_o(cmd_oe),
        .card_clk_o(cck), .card_clk_oe_o(cck_oe), .pwr_state_o(st),
        .on_ack_o(ack), .mask_reload_o(reload)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // timebase: one tick every TDIV cycles, changed at the falling edge
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick = (ph == TDIV - 1);
            ph = (ph + 1) % TDIV;
        end
    end

    // behavioural reference: 0 cycle, 1 off, 2 on, 3 settling
    int m_state = 0, m_prev = 0, m_cnt = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_prev = 0; m_cnt = 0;
        end else begin
            m_prev = m_state;
            case (m_state)
                0: if (req == 2'b01) m_state = 1;
                   else if (req == 2'b10) begin m_state = 3; m_cnt = 0; end
                1: if (req == 2'b00) m_state = 0;
                   else if (req == 2'b10) begin m_state = 3; m_cnt = 0; end
                3: if (req == 2'b00) m_state = 0;
                   else if (req == 2'b01) m_state = 1;
                   else if (tick) begin
                       m_cnt++;
                       if (m_cnt == NT) m_state = 2;
                   end
                default: ;
            endcase
        end
    end

    // compare on every clock, one time unit after the edge
    always @(posedge clk) begin
        #1;
        begin
            logic [31:0] eoe, elv;
            string lt;
            eoe = (m_state == 2) ? 0 : 1;
            elv = (m_state == 1 || m_state == 3) ? 1 : 0;
            lt  = (m_state == 0) ? "R2" : (m_state == 2) ? "R4" : "R3";
            chk(st, m_state, "R10 state (R5 R6 R7 R8 sequence)");
            chk(dat_oe, eoe ? 32'hFF : 32'h0, {lt, " data enables"});
            chk(dat, elv ? 32'hFF : 32'h0, {lt, " data levels"});
            chk({cmd_oe, cck_oe}, {eoe[0], eoe[0]}, {lt, " cmd/clk enables"});
            chk({cmd, cck}, {elv[0], elv[0]}, {lt, " cmd/clk levels"});
            chk(ack, m_state == 2, "R9 acknowledge");
            chk(reload, m_state == 2 && m_prev != 2, "R9 reload strobe");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_req(input logic [1:0] v);
        @(negedge clk);
        req = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 2'b11;
        #1;
        chk(st, 0, "R1 status in reset");
        chk({dat_oe, dat}, {8'hFF, 8'h00}, "R1 lines low in reset");
        cyc(2);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1);
        chk(st, 0, "R1 status after reset");
    endtask

    // request power-on and measure cycles to reach it
    task automatic run_to_on(input int tag_restart);
        int n = 0;
        set_req(2'b10);
        cyc(1);
        chk(st, 2'b11, "R5 settling entered next clock");
        chk(dat, 32'hFF, "R3 lines high while settling");
        set_req(2'b11);
        while (st != 2'b10 && n < 5000) begin
            cyc(1);
            n++;
        end
        checks++;
        if (n < TDIV * (NT - 1) || n > TDIV * NT + 1) begin
            errors++;
            $display("FAIL %s cycles actual=%0d expected=%0d..%0d",
                     tag_restart ? "R7 restarted window" : "R5 window length",
                     n, TDIV * (NT - 1), TDIV * NT + 1);
        end
        chk(ack, 1, "R9 acknowledge at power-on");
    endtask

    initial begin
        do_reset();
        // R6 cycle <-> off
        set_req(2'b01); cyc(1);
        chk(st, 1, "R6 cycle to off");
        set_req(2'b11); cyc(3);
        chk(st, 1, "R6 hold keeps off");
        set_req(2'b00); cyc(1);
        chk(st, 0, "R6 off to cycle");
        set_req(2'b11); cyc(2);
        run_to_on(0);
        // R8: requests ignored in power-on
        set_req(2'b00); cyc(4);
        chk(st, 2, "R8 cycle request ignored");
        chk(dat_oe, 0, "R8 lines stay released");
        set_req(2'b01); cyc(4);
        chk(st, 2, "R8 off request ignored");
        set_req(2'b10); cyc(2);
        do_reset();
        // R7: abandon to off partway, then restart from off
        set_req(2'b10); cyc(1);
        set_req(2'b11); cyc(TDIV * NT / 2);
        set_req(2'b01); cyc(1);
        chk(st, 1, "R7 abandon to off");
        set_req(2'b11); cyc(5);
        chk({cmd, cck}, 2'b11, "R3 off drives high");
        run_to_on(1);
        do_reset();
        // R7: abandon to cycle partway
        set_req(2'b10); cyc(TDIV * 10);
        set_req(2'b00); cyc(1);
        chk(st, 0, "R7 abandon to cycle");
        set_req(2'b11); cyc(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule